// File: doc/BRIEF.md
# Lockable Feature-Control Register with Privileged-Operation Permission Checker

This block holds a 64-bit feature-control register and decides, for every privileged request, whether the request is granted or faults. Configuration software writes the register through a write port. A write is refused with a fault when the register is locked, when it touches a reserved bit, or when it turns on a capability the core lacks. Bit 0 is a sticky lock. Once it is set, the register is frozen until the next power-on reset.

Requests arrive on an issue port and come in three kinds. The first enables virtualization. The second is a secure-leaf call, which carries a 32-bit leaf index and a 7-bit function mask. The third is an attempt to set the secure-mode-enable control bit. The checker combines the request with the register contents, the capability inputs, the secure-mode-enable control bit and the "inside secure mode" status. One clock later it answers with exactly one of three outcomes: grant, general-protection fault (GP) or invalid-opcode fault (UD). A granted query leaf (index 0) also returns the bitmap of supported leaves.

Top module: `featctl_guard`

## Requirements
- R1: After synchronous reset, `cfg_q` is all zeros and `wr_fault` and `resp_valid` are 0.
- R2: A write to an unlocked register that sets only writable bits passes the capability checks. Writable bits are 0, 1, 2, 8 to 15, 17, 18 and 20. Such a write updates `cfg_q` on the next clock, with `wr_fault` at 0 in that cycle.
- R3: While bit 0 of `cfg_q` is 1, every write raises `wr_fault` on the next clock and leaves `cfg_q` unchanged. Only reset clears bit 0.
- R4: A write that sets any reserved bit raises `wr_fault` and does not update `cfg_q`. Reserved bits are 7:3, 16, 19 and 63:21.
- R5: A write setting bit 1 faults unless `cap_virt` and `cap_secure` are both 1. A write setting bit 2 faults unless `cap_virt` is 1. A faulting write does not update `cfg_q`.
- R6: A virtualization-enable request (`req_kind`=0) gets GP when bit 0 is clear. It also gets GP when the mode enable is clear: bit 1 applies while `in_secure`=1, bit 2 while `in_secure`=0. Otherwise it is granted.
- R7: A secure-leaf request (`req_kind`=1) gets UD whenever `ctl_secure_en` is 0.
- R8: Leaf index 1 and every index of 9 or more get UD.
- R9: A defined leaf whose bit in the supported-leaf map is clear gets UD. A granted leaf 0 returns the supported-leaf map (defined leaves only) on `resp_data`. Every other response carries `resp_data`=0.
- R10: Leaf 4, the measured-launch leaf, gets GP in any of three cases: bit 0 is clear, bit 15 is clear, or `req_fn` requests a function i whose enable bit 8+i is clear.
- R11: UD conditions take priority over GP conditions for the same request.
- R12: A set-secure-enable request (`req_kind`=2) gets GP when `cap_secure` is 0 and is granted otherwise. Request kind 3 gets UD.
- R13: Each request cycle is followed in the next cycle by `resp_valid` together with exactly one of `resp_grant`, `resp_gp` and `resp_ud`. A cycle with no request is followed by `resp_valid`=0 and all three outcomes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write attempt |
| wr_data | input | 64 | Value to write |
| wr_fault | output | 1 | GP for the write of the previous cycle |
| cfg_q | output | 64 | Current register contents |
| req_valid | input | 1 | Request issue strobe |
| req_kind | input | 2 | 0 virtualization enable, 1 secure leaf, 2 set secure enable, 3 undefined |
| req_leaf | input | 32 | Secure-leaf index |
| req_fn | input | 7 | Requested launch functions (bit i maps to register bit 8+i) |
| cap_virt | input | 1 | Virtualization is supported |
| cap_secure | input | 1 | Secure mode is supported |
| ctl_secure_en | input | 1 | Secure-mode-enable control bit |
| in_secure | input | 1 | Core is currently inside secure mode |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_grant | output | 1 | Request granted |
| resp_gp | output | 1 | General-protection fault |
| resp_ud | output | 1 | Invalid-opcode fault |
| resp_data | output | 32 | Supported-leaf map on a granted leaf 0, else 0 |

## Verification
The bench builds the block with a supported-leaf map of 0x17D. This leaves defined leaf 7 unsupported, so the map-based UD path of R9 can be exercised alongside the undefined-index path of R8.

The bench sweeps the following and predicts each outcome arithmetically:
- every single-bit write pattern across all 64 bit positions;
- every combination of the two capability inputs with the two virtualization enable bits;
- all sixteen combinations of lock, the two mode enables and the secure status;
- leaf indices 0 to 12 plus far indices, with the control bit both clear and set;
- the launch leaf across lock, global enable and several function masks.

// File: rtl/featctl_pkg.sv
package featctl_pkg;

    localparam int CFG_W       = 64;
    localparam int MAP_W       = 32;
    localparam int LOCK_BIT    = 0;
    localparam int VIRT_IN_BIT = 1;
    localparam int VIRT_OUT_BIT = 2;
    localparam int FN_LO       = 8;
    localparam int FN_W        = 7;
    localparam int LAUNCH_GLB  = FN_LO + FN_W;
    localparam int LAUNCH_LEAF = 4;
    localparam int QUERY_LEAF  = 0;
    localparam int HOLE_LEAF   = 1;

    localparam logic [CFG_W-1:0] CFG_WRITABLE = 64'h0000_0000_0016_FF07;

    typedef enum logic [1:0] {
        REQ_VIRT_ON   = 2'd0,
        REQ_LEAF      = 2'd1,
        REQ_SET_SECEN = 2'd2,
        REQ_UNDEF     = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        V_GRANT = 2'd0,
        V_GP    = 2'd1,
        V_UD    = 2'd2
    } verdict_e;

    typedef struct packed {
        logic            lock;
        logic            virt_in;
        logic            virt_out;
        logic [FN_W-1:0] fn_en;
        logic            launch_en;
    } cfg_view_t;

    typedef struct packed {
        logic defined;
        logic supported;
        logic is_launch;
        logic is_query;
    } leaf_info_t;

    function automatic logic [MAP_W-1:0] defined_mask(input int n);
        logic [MAP_W-1:0] m;
        m = '0;
        for (int i = 0; i < MAP_W; i++) begin
            if (i < n && i != HOLE_LEAF) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/featctl_reg.sv
module featctl_reg
    import featctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             cap_virt,
    input  logic             cap_secure,
    output logic [CFG_W-1:0] cfg_q,
    output logic             wr_fault
);
    logic hits_rsvd;
    logic cap_bad;
    logic refuse;

    always_comb begin
        hits_rsvd = |(wr_data & ~CFG_WRITABLE);
        cap_bad   = (wr_data[VIRT_IN_BIT]  & ~(cap_virt & cap_secure))
                  | (wr_data[VIRT_OUT_BIT] & ~cap_virt);
        refuse    = cfg_q[LOCK_BIT] | hits_rsvd | cap_bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            wr_fault <= 1'b0;
        end else begin
            wr_fault <= wr_en & refuse;
            if (wr_en && !refuse) cfg_q <= wr_data;
        end
    end
endmodule

// File: rtl/featctl_leaf_decode.sv
module featctl_leaf_decode
    import featctl_pkg::*;
#(
    parameter int              LEAF_W     = 32,
    parameter int              NUM_LEAVES = 9,
    parameter logic [MAP_W-1:0] LEAF_MAP  = 32'h0000_01FD
) (
    input  logic [LEAF_W-1:0] leaf_idx,
    output leaf_info_t        info,
    output logic [MAP_W-1:0]  eff_map
);
    localparam logic [MAP_W-1:0] DEF_MASK = defined_mask(NUM_LEAVES);
    localparam logic [MAP_W-1:0] SUP_MASK = DEF_MASK & LEAF_MAP;

    logic [NUM_LEAVES-1:0] hit;

    for (genvar i = 0; i < NUM_LEAVES; i++) begin : g_hit
        assign hit[i] = (leaf_idx == LEAF_W'(i));
    end

    always_comb begin
        info.defined   = |(hit & DEF_MASK[NUM_LEAVES-1:0]);
        info.supported = |(hit & SUP_MASK[NUM_LEAVES-1:0]);
        info.is_launch = hit[LAUNCH_LEAF];
        info.is_query  = hit[QUERY_LEAF];
        eff_map        = SUP_MASK;
    end
endmodule

// File: rtl/featctl_judge.sv
module featctl_judge
    import featctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  req_kind_e       kind,
    input  cfg_view_t       view,
    input  leaf_info_t      info,
    input  logic [MAP_W-1:0] eff_map,
    input  logic [FN_W-1:0] req_fn,
    input  logic            cap_secure,
    input  logic            ctl_secure_en,
    input  logic            in_secure,
    output logic            resp_valid,
    output logic            resp_grant,
    output logic            resp_gp,
    output logic            resp_ud,
    output logic [MAP_W-1:0] resp_data
);
    verdict_e         verdict;
    logic             mode_ok;
    logic             launch_bad;
    logic [MAP_W-1:0] data_d;

    always_comb begin
        mode_ok    = in_secure ? view.virt_in : view.virt_out;
        launch_bad = ~view.lock | ~view.launch_en | (|(req_fn & ~view.fn_en));
        verdict    = V_UD;
        unique case (kind)
            REQ_VIRT_ON:   verdict = (view.lock && mode_ok) ? V_GRANT : V_GP;
            REQ_LEAF: begin
                if (!ctl_secure_en)                        verdict = V_UD;
                else if (!info.defined || !info.supported) verdict = V_UD;
                else if (info.is_launch && launch_bad)     verdict = V_GP;
                else                                       verdict = V_GRANT;
            end
            REQ_SET_SECEN: verdict = cap_secure ? V_GRANT : V_GP;
            default:       verdict = V_UD;
        endcase
        data_d = (kind == REQ_LEAF && verdict == V_GRANT && info.is_query) ? eff_map : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_grant <= 1'b0;
            resp_gp    <= 1'b0;
            resp_ud    <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= req_valid;
            resp_grant <= req_valid && verdict == V_GRANT;
            resp_gp    <= req_valid && verdict == V_GP;
            resp_ud    <= req_valid && verdict == V_UD;
            resp_data  <= req_valid ? data_d : '0;
        end
    end
endmodule

// File: rtl/featctl_guard.sv
module featctl_guard
    import featctl_pkg::*;
#(
    parameter int               LEAF_W     = 32,
    parameter int               NUM_LEAVES = 9,
    parameter logic [MAP_W-1:0] LEAF_MAP   = 32'h0000_01FD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [63:0]       wr_data,
    output logic              wr_fault,
    output logic [63:0]       cfg_q,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [LEAF_W-1:0] req_leaf,
    input  logic [6:0]        req_fn,
    input  logic              cap_virt,
    input  logic              cap_secure,
    input  logic              ctl_secure_en,
    input  logic              in_secure,
    output logic              resp_valid,
    output logic              resp_grant,
    output logic              resp_gp,
    output logic              resp_ud,
    output logic [31:0]       resp_data
);
    cfg_view_t        view;
    leaf_info_t       info;
    logic [MAP_W-1:0] eff_map;
    req_kind_e        kind;

    featctl_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cap_virt   (cap_virt),
        .cap_secure (cap_secure),
        .cfg_q      (cfg_q),
        .wr_fault   (wr_fault)
    );

    always_comb begin
        view.lock      = cfg_q[LOCK_BIT];
        view.virt_in   = cfg_q[VIRT_IN_BIT];
        view.virt_out  = cfg_q[VIRT_OUT_BIT];
        view.fn_en     = cfg_q[FN_LO +: FN_W];
        view.launch_en = cfg_q[LAUNCH_GLB];
        kind           = req_kind_e'(req_kind);
    end

    featctl_leaf_decode #(
        .LEAF_W     (LEAF_W),
        .NUM_LEAVES (NUM_LEAVES),
        .LEAF_MAP   (LEAF_MAP)
    ) u_dec (
        .leaf_idx (req_leaf),
        .info     (info),
        .eff_map  (eff_map)
    );

    featctl_judge u_judge (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .kind          (kind),
        .view          (view),
        .info          (info),
        .eff_map       (eff_map),
        .req_fn        (req_fn),
        .cap_secure    (cap_secure),
        .ctl_secure_en (ctl_secure_en),
        .in_secure     (in_secure),
        .resp_valid    (resp_valid),
        .resp_grant    (resp_grant),
        .resp_gp       (resp_gp),
        .resp_ud       (resp_ud),
        .resp_data     (resp_data)
    );
endmodule

// File: rtl/featctl_guard_chk.sv
module featctl_guard_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [63:0] wr_data,
    input logic        wr_fault,
    input logic [63:0] cfg_q,
    input logic        req_valid,
    input logic [1:0]  req_kind,
    input logic        ctl_secure_en,
    input logic        resp_valid,
    input logic        resp_grant,
    input logic        resp_gp,
    input logic        resp_ud
);
    localparam logic [63:0] RSVD = ~64'h0000_0000_0016_FF07;

    // R13
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $onehot({resp_grant, resp_gp, resp_ud}));

    // R13
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    // R13
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid && !resp_grant && !resp_gp && !resp_ud);

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_q[0] |=> cfg_q[0]);

    // R3
    locked_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && cfg_q[0] |=> wr_fault && $stable(cfg_q));

    // R4
    reserved_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && ((wr_data & RSVD) != 64'd0) |=> wr_fault && $stable(cfg_q));

    // R7
    leaf_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == 2'd1 && !ctl_secure_en |=> resp_ud);

    // R6
    virt_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == 2'd0 && !cfg_q[0] |=> resp_gp);
endmodule

bind featctl_guard featctl_guard_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .wr_fault      (wr_fault),
    .cfg_q         (cfg_q),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .ctl_secure_en (ctl_secure_en),
    .resp_valid    (resp_valid),
    .resp_grant    (resp_grant),
    .resp_gp       (resp_gp),
    .resp_ud       (resp_ud)
);

// File: tb/tb_featctl_guard.sv
`timescale 1ns/1ps
module tb_featctl_guard;
    localparam logic [31:0] MAP = 32'h0000_017D;
    localparam logic [63:0] WRITABLE = 64'h0000_0000_0016_FF07;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        wr_fault;
    logic [63:0] cfg_q;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_leaf = '0;
    logic [6:0]  req_fn = '0;
    logic        cap_virt = 1'b1;
    logic        cap_secure = 1'b1;
    logic        ctl_secure_en = 1'b1;
    logic        in_secure = 1'b0;
    logic        resp_valid, resp_grant, resp_gp, resp_ud;
    logic [31:0] resp_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    featctl_guard #(.LEAF_W(32), .NUM_LEAVES(9), .LEAF_MAP(MAP)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_fault(wr_fault),
        .cfg_q(cfg_q), .req_valid(req_valid), .req_kind(req_kind), .req_leaf(req_leaf),
        .req_fn(req_fn), .cap_virt(cap_virt), .cap_secure(cap_secure),
        .ctl_secure_en(ctl_secure_en), .in_secure(in_secure), .resp_valid(resp_valid),
        .resp_grant(resp_grant), .resp_gp(resp_gp), .resp_ud(resp_ud), .resp_data(resp_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_try(input logic [63:0] d, input bit cv, input bit cs,
                          input bit exp_f, input logic [63:0] exp_cfg, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; cap_virt = cv; cap_secure = cs;
        @(negedge clk);
        wr_en = 1'b0;
        check({tag, " wr_fault"}, {63'd0, wr_fault}, {63'd0, exp_f});
        check({tag, " cfg"}, cfg_q, exp_cfg);
    endtask

    // code: 0 grant, 1 GP, 2 UD
    function automatic int predict(input int kind, input logic [31:0] leaf, input logic [6:0] fn,
                                   input logic [63:0] cfg, input bit ins, input bit sen, input bit cs);
        bit defd, sup, launch_ok;
        if (kind == 0) return (cfg[0] && (ins ? cfg[1] : cfg[2])) ? 0 : 1;
        if (kind == 2) return cs ? 0 : 1;
        if (kind == 3) return 2;
        if (!sen) return 2;
        defd = (leaf <= 32'd8) && (leaf != 32'd1);
        sup  = defd && MAP[leaf[4:0]];
        if (!sup) return 2;
        launch_ok = cfg[0] && cfg[15] && ((fn & ~cfg[14:8]) == 7'd0);
        if (leaf == 32'd4 && !launch_ok) return 1;
        return 0;
    endfunction

    task automatic req_try(input int kind, input logic [31:0] leaf, input logic [6:0] fn,
                           input bit ins, input bit sen, input bit cs, input string tag);
        int code;
        logic [2:0] exp_o;
        logic [31:0] exp_d;
        code = predict(kind, leaf, fn, cfg_q, ins, sen, cs);
        exp_o = (code == 0) ? 3'b100 : (code == 1) ? 3'b010 : 3'b001;
        exp_d = (kind == 1 && code == 0 && leaf == 32'd0) ? (MAP & 32'h0000_01FD) : 32'd0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(kind); req_leaf = leaf; req_fn = fn;
        in_secure = ins; ctl_secure_en = sen; cap_secure = cs;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R13 valid"}, {63'd0, resp_valid}, 64'd1);
        check({tag, " outcome"}, {61'd0, resp_grant, resp_gp, resp_ud}, {61'd0, exp_o});
        check({tag, " R9 data"}, {32'd0, resp_data}, {32'd0, exp_d});
    endtask

    initial begin
        #(150000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        @(negedge clk);
        check("R1 cfg", cfg_q, 64'd0);
        check("R1 wr_fault", {63'd0, wr_fault}, 64'd0);
        check("R1 resp_valid", {63'd0, resp_valid}, 64'd0);

        // R2 R5 capability sweep over bits 1 and 2
        for (int c = 0; c < 4; c++) begin
            for (int b = 0; b < 4; b++) begin
                logic [63:0] d;
                bit cv, cs, bad;
                cv = c[0]; cs = c[1];
                d = 64'h8000 | (64'(b[0]) << 1) | (64'(b[1]) << 2);
                bad = (b[0] && !(cv && cs)) || (b[1] && !cv);
                do_reset();
                wr_try(d, cv, cs, bad, bad ? 64'd0 : d, "R5 cap");
            end
        end

        // R2 R4 every single bit position
        for (int k = 0; k < 64; k++) begin
            logic [63:0] d;
            bit ok;
            d = 64'd1 << k;
            ok = WRITABLE[k];
            do_reset();
            wr_try(d, 1'b1, 1'b1, !ok, ok ? d : 64'd0, ok ? "R2 legal bit" : "R4 reserved bit");
        end

        // R3 lock freezes the register until reset
        do_reset();
        wr_try(64'h0016_FF07, 1'b1, 1'b1, 1'b0, 64'h0016_FF07, "R2 full");
        wr_try(64'd0, 1'b1, 1'b1, 1'b1, 64'h0016_FF07, "R3 clear attempt");
        wr_try(64'h0000_FF06, 1'b1, 1'b1, 1'b1, 64'h0016_FF07, "R3 unlock attempt");
        do_reset();
        @(negedge clk);
        check("R3 reset clears lock", cfg_q, 64'd0);

        // R6 virtualization enable sweep
        for (int v = 0; v < 16; v++) begin
            do_reset();
            wr_try(64'(v[2:0]), 1'b1, 1'b1, 1'b0, 64'(v[2:0]), "R6 setup");
            req_try(0, 32'd0, 7'd0, v[3], 1'b1, 1'b1, "R6 virt");
        end

        // R7 R8 R9 R11 leaf sweep with launch fully enabled
        do_reset();
        wr_try(64'h0000_FF01, 1'b1, 1'b1, 1'b0, 64'h0000_FF01, "R9 setup");
        for (int se = 0; se < 2; se++) begin
            for (int l = 0; l < 13; l++) begin
                req_try(1, 32'(l), 7'h7F, 1'b0, se[0], 1'b1, se[0] ? "R8 R9 leaf" : "R7 leaf");
            end
            req_try(1, 32'd32, 7'd0, 1'b0, se[0], 1'b1, "R8 far leaf");
            req_try(1, 32'hFFFF_FFFF, 7'd0, 1'b0, se[0], 1'b1, "R8 top leaf");
            req_try(1, 32'h0000_0107, 7'd0, 1'b0, se[0], 1'b1, "R8 aliased leaf");
        end

        // R10 R11 launch leaf conditions
        for (int m = 0; m < 4; m++) begin
            logic [63:0] cfg;
            cfg = 64'(m[0]) | (64'(m[1]) << 15) | (64'h55 << 8);
            do_reset();
            wr_try(cfg, 1'b1, 1'b1, 1'b0, cfg, "R10 setup");
            for (int f = 0; f < 5; f++) begin
                logic [6:0] fn;
                fn = (f == 0) ? 7'h00 : (f == 1) ? 7'h01 : (f == 2) ? 7'h02 : (f == 3) ? 7'h55 : 7'h7F;
                req_try(1, 32'd4, fn, 1'b0, 1'b1, 1'b1, "R10 launch");
            end
            req_try(1, 32'd4, 7'h7F, 1'b0, 1'b0, 1'b1, "R11 launch disabled");
            req_try(1, 32'd7, 7'h00, 1'b0, 1'b1, 1'b1, "R11 unsupported leaf");
        end

        // R12 set-secure-enable and undefined kind
        req_try(2, 32'd0, 7'd0, 1'b0, 1'b0, 1'b0, "R12 no cap");
        req_try(2, 32'd0, 7'd0, 1'b0, 1'b0, 1'b1, "R12 cap");
        req_try(3, 32'd0, 7'd0, 1'b0, 1'b1, 1'b1, "R12 kind3");

        // R13 idle cycle and back-to-back requests
        @(negedge clk);
        check("R13 idle valid", {63'd0, resp_valid}, 64'd0);
        check("R13 idle outcomes", {61'd0, resp_grant, resp_gp, resp_ud}, 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule